// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block produces the cycle-level handshakes for an asynchronous NAND flash bus that is 8 or 16 bits wide. A sequencer outside the block presents one bus cycle at a time: a command latch, an address latch, a data write or a data read. The block answers with the write-enable or read-enable strobe, the command and address latch enables, the output-enable for the data pads and a one-cycle read-data valid pulse. Every phase length comes from a packed word of cycle counts.

Timing and bus-width settings are written into shadow registers. They reach the active copy only when an update command carrying the right code arrives, so software can stage a full set of timings without disturbing a cycle that is already running. Read data is always captured at the end of the first clock with read-enable low, whatever the clock period. A hold counter keeps reads back after command and address latches, and after the device reports ready.

Top module: `nand_strobe_gen`

## Requirements
- R1: After reset the active timing word is 0x125144, the bus is 8-bit (`bus16` = 0), `weN` and `reN` are high, and `cle`, `ale`, `padOe` and `rdValid` are low.
- R2: The timing word is packed as follows, in clock cycles: read cycle `rc` [3:0], write cycle `wc` [7:4], access time [10:8], write pulse `wp` [13:11], command-to-read hold `clr` [16:14], address-to-read hold `ar` [19:17], ready-to-read hold `rr` [22:20]. The access-time field is stored and reported but does not move the capture point.
- R3: A write to the timing word or the width word changes only the shadow copy. The active copy (`cfgActive`, `bus16`) loads from the shadow only when `updEn` is high with `updCs` = 4 and `updType` = 2. Any other code leaves it unchanged.
- R4: A width write is stored only for the values 0 (8-bit) and 1 (16-bit). Any other value leaves the shadow width unchanged.
- R5: A command, address or data-write request (`reqKind` 0, 1, 3) accepted at a clock edge drives `weN` low from the next cycle for max(wp,1) cycles. `weN` then stays high for max(max(wc,2) − max(wp,1), 1) cycles. `reqReady` is low for the whole cycle and returns high in the cycle after it.
- R6: A read request (`reqKind` 2) drives `reN` low from the cycle after acceptance for max(rc,2) − 1 cycles, then high for one cycle. `reqReady` returns high after that.
- R7: `padIn` is captured at the end of the first cycle with `reN` low. `rdValid` is high for exactly the next cycle, which is the second cycle after the accepting edge, with the captured value on `rdData`.
- R8: `cle` is high only during a command cycle and `ale` only during an address cycle. `padOe` is high during every command, address and data-write cycle. Command and address cycles drive only the low byte of `padOut`.
- R9: In 8-bit mode the upper byte of `padOut` and of `rdData` is zero.
- R10: After a command cycle ends, a read is refused for `clr` cycles. After an address cycle ends, a read is refused for `ar` cycles.
- R11: A read is refused while `devReady` is low. It is also refused in the cycle in which `devReady` rises and for `rr` cycles after the first edge that samples it high.
- R12: `weN` and `reN` are never low together, and `reqReady` is high only while no bus cycle is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for the shadow timing word |
| cfgWrData | input | 23 | Packed timing word (R2 layout) |
| widthWrEn | input | 1 | Write strobe for the shadow width word |
| widthWrData | input | 2 | Width code: 0 = 8-bit, 1 = 16-bit |
| updEn | input | 1 | Update command strobe |
| updCs | input | 3 | Update command chip-select field (must be 4) |
| updType | input | 2 | Update command type field (must be 2) |
| reqValid | input | 1 | Bus-cycle request present |
| reqKind | input | 2 | 0 command, 1 address, 2 read, 3 data write |
| reqData | input | 16 | Byte or word to drive during a write-type cycle |
| reqReady | output | 1 | Request is accepted at the edge where both are high |
| devReady | input | 1 | Device ready/busy line, high = ready |
| padIn | input | 16 | Data returned by the device |
| padOut | output | 16 | Data driven toward the device |
| padOe | output | 1 | Output enable for the data pads |
| weN | output | 1 | Write-enable strobe, active low |
| reN | output | 1 | Read-enable strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| rdValid | output | 1 | One-cycle pulse marking captured read data |
| rdData | output | 16 | Captured read data |
| cfgActive | output | 23 | Timing word in use |
| bus16 | output | 1 | Active bus width, 1 = 16-bit |

## Verification
Counting from the accepting edge, the first strobe-low cycle is the one right after it, `rdValid` appears in the second cycle, and `reqReady` comes back in the cycle after the last busy phase. The bench drives inputs and samples outputs only on falling edges. For each request it counts falling edges from acceptance, so strobe length, busy length and the index of the `rdValid` pulse are compared as counts and not as absolute times. Configuration changes appear at the falling edge that follows the update edge. Hold windows are counted from the first idle sample after a latch cycle, or from the sample in which `devReady` is raised.

// File: rtl/nand_tim_pkg.sv
package nand_tim_pkg;

  localparam int CNT_W   = 4;
  localparam int SHORT_W = 3;
  localparam int CFG_W   = 2 * CNT_W + 5 * SHORT_W;

  localparam logic [2:0] UPD_CS   = 3'd4;
  localparam logic [1:0] UPD_TYPE = 2'd2;

  // Field order MSB to LSB fixes the bit positions of the packed word.
  typedef struct packed {
    logic [SHORT_W-1:0] rr;
    logic [SHORT_W-1:0] ar;
    logic [SHORT_W-1:0] clr;
    logic [SHORT_W-1:0] wp;
    logic [SHORT_W-1:0] rea;
    logic [CNT_W-1:0]   wc;
    logic [CNT_W-1:0]   rc;
  } cycleCfg_t;

  typedef enum logic [1:0] {
    KIND_CMD   = 2'd0,
    KIND_ADDR  = 2'd1,
    KIND_READ  = 2'd2,
    KIND_WRITE = 2'd3
  } reqKind_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WLOW,
    PH_WHIGH,
    PH_RLOW,
    PH_RHIGH
  } phase_e;

  // Control to datapath strobes.
  typedef struct packed {
    logic loadOut;
    logic capture;
  } strobe_t;

endpackage

// File: rtl/nand_tim_cfg.sv
module nand_tim_cfg
  import nand_tim_pkg::*;
#(
  parameter logic [CFG_W-1:0] RESET_CFG = 23'h125144,
  parameter int WIDTH_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [CFG_W-1:0]   cfgWrData,
  input  logic               widthWrEn,
  input  logic [WIDTH_W-1:0] widthWrData,
  input  logic               updEn,
  input  logic [2:0]         updCs,
  input  logic [1:0]         updType,
  output cycleCfg_t          cfgActive,
  output logic               bus16
);

  cycleCfg_t shadowCfg;
  logic      shadowWide;
  logic      updHit;
  logic      widthLegal;

  assign updHit     = updEn && (updCs == UPD_CS) && (updType == UPD_TYPE);
  assign widthLegal = (widthWrData < WIDTH_W'(2));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shadowCfg  <= cycleCfg_t'(RESET_CFG);
      shadowWide <= 1'b0;
    end else begin
      if (cfgWrEn) shadowCfg <= cycleCfg_t'(cfgWrData);
      if (widthWrEn && widthLegal) shadowWide <= widthWrData[0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgActive <= cycleCfg_t'(RESET_CFG);
      bus16     <= 1'b0;
    end else if (updHit) begin
      cfgActive <= shadowCfg;
      bus16     <= shadowWide;
    end
  end

endmodule

// File: rtl/nand_tim_ctrl.sv
module nand_tim_ctrl
  import nand_tim_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic [CNT_W-1:0]   rcCyc,
  input  logic [CNT_W-1:0]   wcCyc,
  input  logic [SHORT_W-1:0] wpCyc,
  input  logic [SHORT_W-1:0] clrCyc,
  input  logic [SHORT_W-1:0] arCyc,
  input  logic [SHORT_W-1:0] rrCyc,
  input  logic               reqValid,
  input  logic [1:0]         reqKind,
  input  logic               devReady,
  output logic               reqReady,
  output logic               weN,
  output logic               reN,
  output logic               cle,
  output logic               ale,
  output logic               padOe,
  output strobe_t            strb
);

  localparam int PAD_W = CNT_W - SHORT_W;

  phase_e             phase, phaseNext;
  logic [CNT_W-1:0]   cnt, cntNext;
  logic [1:0]         kindQ;
  logic [SHORT_W-1:0] hold, holdNext;
  logic               devReadyQ;
  logic               rdFirst;

  logic [CNT_W-1:0]   rcEff, wcEff, wpEff, wHigh;
  logic               isRead, readOk, accept, wrEnd, readyRise;

  // Clamp programmed counts to the legal minimums.
  assign rcEff = (rcCyc < CNT_W'(2)) ? CNT_W'(2) : rcCyc;
  assign wcEff = (wcCyc < CNT_W'(2)) ? CNT_W'(2) : wcCyc;
  assign wpEff = (wpCyc == '0) ? CNT_W'(1) : {{PAD_W{1'b0}}, wpCyc};
  assign wHigh = (wcEff > wpEff) ? (wcEff - wpEff) : CNT_W'(1);

  assign isRead    = (reqKind == KIND_READ);
  assign readyRise = devReady && !devReadyQ;
  assign readOk    = devReady && devReadyQ && (hold == '0);
  assign reqReady  = (phase == PH_IDLE) && (!isRead || readOk);
  assign accept    = reqValid && reqReady;
  assign wrEnd     = (phase == PH_WHIGH) && (cnt == '0);

  always_comb begin
    phaseNext = phase;
    cntNext   = cnt;
    unique case (phase)
      PH_IDLE: begin
        if (accept) begin
          if (isRead) begin
            phaseNext = PH_RLOW;
            cntNext   = rcEff - CNT_W'(2);
          end else begin
            phaseNext = PH_WLOW;
            cntNext   = wpEff - CNT_W'(1);
          end
        end
      end
      PH_WLOW: begin
        if (cnt == '0) begin
          phaseNext = PH_WHIGH;
          cntNext   = wHigh - CNT_W'(1);
        end else begin
          cntNext = cnt - CNT_W'(1);
        end
      end
      PH_WHIGH: begin
        if (cnt == '0) phaseNext = PH_IDLE;
        else           cntNext   = cnt - CNT_W'(1);
      end
      PH_RLOW: begin
        if (cnt == '0) phaseNext = PH_RHIGH;
        else           cntNext   = cnt - CNT_W'(1);
      end
      PH_RHIGH: phaseNext = PH_IDLE;
      default:  phaseNext = PH_IDLE;
    endcase
  end

  // Read hold: counts down, reloads with the largest pending delay.
  always_comb begin
    holdNext = (hold != '0) ? (hold - SHORT_W'(1)) : hold;
    if (wrEnd && (kindQ == KIND_CMD) && (clrCyc > holdNext))  holdNext = clrCyc;
    if (wrEnd && (kindQ == KIND_ADDR) && (arCyc > holdNext))  holdNext = arCyc;
    if (readyRise && (rrCyc > holdNext))                      holdNext = rrCyc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      kindQ     <= KIND_CMD;
      hold      <= '0;
      devReadyQ <= 1'b0;
      rdFirst   <= 1'b0;
    end else begin
      phase     <= phaseNext;
      cnt       <= cntNext;
      hold      <= holdNext;
      devReadyQ <= devReady;
      rdFirst   <= accept && isRead;
      if (accept) kindQ <= reqKind;
    end
  end

  assign weN   = (phase != PH_WLOW);
  assign reN   = (phase != PH_RLOW);
  assign padOe = (phase == PH_WLOW) || (phase == PH_WHIGH);
  assign cle   = padOe && (kindQ == KIND_CMD);
  assign ale   = padOe && (kindQ == KIND_ADDR);

  assign strb.loadOut = accept && !isRead;
  assign strb.capture = rdFirst;

endmodule

// File: rtl/nand_tim_data.sv
module nand_tim_data
  import nand_tim_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              bus16,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int BYTE_W = 8;

  logic [DATA_W-1:0] dataQ;
  logic              byteOnlyQ;
  logic [DATA_W-1:0] rdNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ     <= '0;
      byteOnlyQ <= 1'b0;
    end else if (strb.loadOut) begin
      dataQ     <= reqData;
      byteOnlyQ <= (reqKind == KIND_CMD) || (reqKind == KIND_ADDR);
    end
  end

  generate
    if (DATA_W > BYTE_W) begin : gWide
      logic outNarrow;
      assign outNarrow = byteOnlyQ || !bus16;
      assign padOut = outNarrow ? {{(DATA_W-BYTE_W){1'b0}}, dataQ[BYTE_W-1:0]} : dataQ;
      assign rdNext = bus16 ? padIn : {{(DATA_W-BYTE_W){1'b0}}, padIn[BYTE_W-1:0]};
    end else begin : gNarrow
      assign padOut = dataQ;
      assign rdNext = padIn;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strb.capture;
      if (strb.capture) rdData <= rdNext;
    end
  end

endmodule

// File: rtl/nand_strobe_gen.sv
module nand_strobe_gen
  import nand_tim_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [CFG_W-1:0] RESET_CFG = 23'h125144
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              widthWrEn,
  input  logic [1:0]        widthWrData,
  input  logic              updEn,
  input  logic [2:0]        updCs,
  input  logic [1:0]        updType,
  input  logic              reqValid,
  input  logic [1:0]        reqKind,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  input  logic              devReady,
  input  logic [DATA_W-1:0] padIn,
  output logic [DATA_W-1:0] padOut,
  output logic              padOe,
  output logic              weN,
  output logic              reN,
  output logic              cle,
  output logic              ale,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData,
  output logic [CFG_W-1:0]  cfgActive,
  output logic              bus16
);

  cycleCfg_t cfgQ;
  strobe_t   strb;

  nand_tim_cfg #(.RESET_CFG(RESET_CFG), .WIDTH_W(2)) u_cfg (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .widthWrEn(widthWrEn), .widthWrData(widthWrData),
    .updEn(updEn), .updCs(updCs), .updType(updType),
    .cfgActive(cfgQ), .bus16(bus16)
  );

  nand_tim_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .rcCyc(cfgQ.rc), .wcCyc(cfgQ.wc), .wpCyc(cfgQ.wp),
    .clrCyc(cfgQ.clr), .arCyc(cfgQ.ar), .rrCyc(cfgQ.rr),
    .reqValid(reqValid), .reqKind(reqKind), .devReady(devReady),
    .reqReady(reqReady), .weN(weN), .reN(reN),
    .cle(cle), .ale(ale), .padOe(padOe), .strb(strb)
  );

  nand_tim_data #(.DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .bus16(bus16),
    .reqKind(reqKind), .reqData(reqData), .padIn(padIn),
    .padOut(padOut), .rdValid(rdValid), .rdData(rdData)
  );

  assign cfgActive = cfgQ;

endmodule

// File: rtl/nand_strobe_gen_chk.sv
module nand_strobe_gen_chk (
  input logic        clk,
  input logic        rstN,
  input logic        updEn,
  input logic [2:0]  updCs,
  input logic [1:0]  updType,
  input logic        reqValid,
  input logic [1:0]  reqKind,
  input logic        reqReady,
  input logic        devReady,
  input logic        padOe,
  input logic        weN,
  input logic        reN,
  input logic        cle,
  input logic        ale,
  input logic        rdValid,
  input logic [22:0] cfgActive,
  input logic        bus16
);

  assert_cfg_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgActive) |-> $past(updEn && updCs == 3'd4 && updType == 2'd2));

  assert_width_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(bus16) |-> $past(updEn && updCs == 3'd4 && updType == 2'd2));

  assert_we_start_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(weN) |-> $past(reqValid && reqReady && reqKind != 2'd2));

  assert_re_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reN) |-> $past(reqValid && reqReady && reqKind == 2'd2));

  assert_capture_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> $past(!reN));

  assert_latch_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cle || ale) |-> (padOe && !(cle && ale)));

  assert_ready_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqKind == 2'd2) |-> devReady);

  assert_strobe_excl_R12: assert property (@(posedge clk) disable iff (!rstN)
    !(!weN && !reN));

  assert_idle_ready_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (weN && reN && !padOe));

endmodule

bind nand_strobe_gen nand_strobe_gen_chk u_chk (
  .clk(clk), .rstN(rstN),
  .updEn(updEn), .updCs(updCs), .updType(updType),
  .reqValid(reqValid), .reqKind(reqKind), .reqReady(reqReady),
  .devReady(devReady), .padOe(padOe), .weN(weN), .reN(reN),
  .cle(cle), .ale(ale), .rdValid(rdValid),
  .cfgActive(cfgActive), .bus16(bus16)
);

// File: tb/nand_strobe_gen_tb.sv
module nand_strobe_gen_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn, widthWrEn, updEn, reqValid, devReady;
  logic [22:0] cfgWrData;
  logic [1:0]  widthWrData, updType, reqKind;
  logic [2:0]  updCs;
  logic [15:0] reqData, padIn, padOut, rdData;
  logic        reqReady, padOe, weN, reN, cle, ale, rdValid, bus16;
  logic [22:0] cfgActive;

  int  total = 0;
  int  bad = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  nand_strobe_gen u_dut (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .widthWrEn(widthWrEn), .widthWrData(widthWrData),
    .updEn(updEn), .updCs(updCs), .updType(updType),
    .reqValid(reqValid), .reqKind(reqKind), .reqData(reqData),
    .reqReady(reqReady), .devReady(devReady), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .weN(weN), .reN(reN),
    .cle(cle), .ale(ale), .rdValid(rdValid), .rdData(rdData),
    .cfgActive(cfgActive), .bus16(bus16)
  );

  // rc, wc, wp, kind, data, expected strobe-low cycles, expected busy cycles
  localparam int NVEC = 9;
  localparam logic [37:0] VEC [NVEC] = '{
    {4'd2,  4'd2, 3'd1, 2'd3, 16'hA5C3, 4'd1,  5'd2},
    {4'd5,  4'd9, 3'd3, 2'd3, 16'h1234, 4'd3,  5'd9},
    {4'd0,  4'd0, 3'd0, 2'd3, 16'h0F0F, 4'd1,  5'd2},
    {4'd4,  4'd3, 3'd7, 2'd3, 16'hBEEF, 4'd7,  5'd8},
    {4'd2,  4'd3, 3'd2, 2'd3, 16'h5A5A, 4'd2,  5'd3},
    {4'd2,  4'd0, 3'd0, 2'd2, 16'hABCD, 4'd1,  5'd2},
    {4'd7,  4'd2, 3'd1, 2'd2, 16'h1357, 4'd6,  5'd7},
    {4'd0,  4'd5, 3'd1, 2'd2, 16'h2468, 4'd1,  5'd2},
    {4'd15, 4'd2, 3'd1, 2'd2, 16'hFEDC, 4'd14, 5'd15}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic logic [22:0] packCfg(input logic [3:0] rc, input logic [3:0] wc,
                                          input logic [2:0] rea, input logic [2:0] wp,
                                          input logic [2:0] clr, input logic [2:0] ar,
                                          input logic [2:0] rr);
    return {rr, ar, clr, wp, rea, wc, rc};
  endfunction

  task automatic commit(input logic [2:0] cs, input logic [1:0] typ);
    updEn = 1'b1; updCs = cs; updType = typ;
    step();
    updEn = 1'b0;
  endtask

  task automatic setCfg(input logic [22:0] w);
    cfgWrEn = 1'b1; cfgWrData = w;
    step();
    cfgWrEn = 1'b0;
    commit(3'd4, 2'd2);
  endtask

  task automatic setWidth(input logic [1:0] v);
    widthWrEn = 1'b1; widthWrData = v;
    step();
    widthWrEn = 1'b0;
    commit(3'd4, 2'd2);
  endtask

  task automatic runReq(input logic [1:0] kind, input logic [15:0] data,
                        output int lowCnt, output int busyCnt, output int rdAt,
                        output logic [15:0] firstPad, output logic firstCle,
                        output logic firstAle, output logic firstOe);
    int  guard;
    bit  bothLow;
    reqKind = kind; reqData = data; reqValid = 1'b1;
    #1;
    guard = 0;
    while (!reqReady && guard < 100) begin
      step(); guard++;
    end
    step();
    reqValid = 1'b0;
    lowCnt = 0; busyCnt = 0; rdAt = 0; bothLow = 0;
    firstPad = '0; firstCle = 0; firstAle = 0; firstOe = 0;
    for (int idx = 1; idx <= 40 && !reqReady; idx++) begin
      busyCnt++;
      if ((kind == 2'd2) ? !reN : !weN) lowCnt++;
      if (rdValid) rdAt = idx;
      if (!weN && !reN) bothLow = 1;
      if (idx == 1) begin
        firstPad = padOut; firstCle = cle; firstAle = ale; firstOe = padOe;
      end
      step();
    end
    chk("R12 strobes never low together", 32'(bothLow), 32'd0);
  endtask

  task automatic countReadHold(output int cnt);
    reqKind = 2'd2;
    #1;
    cnt = 0;
    while (!reqReady && cnt < 40) begin
      cnt++;
      step();
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired (R12) actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lowCnt, busyCnt, rdAt, holdCnt;
    logic [15:0] fPad;
    logic fCle, fAle, fOe;
    logic [22:0] stageW;

    rstN = 1'b0; cfgWrEn = 0; widthWrEn = 0; updEn = 0; reqValid = 0;
    devReady = 1'b1; cfgWrData = '0; widthWrData = '0; updType = '0;
    updCs = '0; reqKind = 2'd3; reqData = '0; padIn = '0;
    repeat (3) step();
    rstN = 1'b1;
    step();

    // R1: reset state
    chk("R1 cfgActive", 32'(cfgActive), 32'h125144);
    chk("R1 bus16", 32'(bus16), 32'd0);
    chk("R1 weN", 32'(weN), 32'd1);
    chk("R1 reN", 32'(reN), 32'd1);
    chk("R1 cle/ale", 32'({cle, ale}), 32'd0);
    chk("R1 padOe", 32'(padOe), 32'd0);
    chk("R1 rdValid", 32'(rdValid), 32'd0);

    // R3: shadow writes invisible until the right update code
    stageW = packCfg(4'd3, 4'd6, 3'd1, 3'd2, 3'd3, 3'd5, 3'd4);
    cfgWrEn = 1'b1; cfgWrData = stageW; step(); cfgWrEn = 1'b0;
    widthWrEn = 1'b1; widthWrData = 2'd1; step(); widthWrEn = 1'b0;
    step();
    chk("R3 cfg before update", 32'(cfgActive), 32'h125144);
    chk("R3 width before update", 32'(bus16), 32'd0);
    commit(3'd3, 2'd2);
    chk("R3 wrong cs ignored", 32'(cfgActive), 32'h125144);
    commit(3'd4, 2'd1);
    chk("R3 wrong type ignored", 32'(cfgActive), 32'h125144);
    chk("R3 width wrong type", 32'(bus16), 32'd0);
    commit(3'd4, 2'd2);
    chk("R3 cfg after update", 32'(cfgActive), 32'(stageW));
    chk("R3 width after update", 32'(bus16), 32'd1);
    chk("R2 wp field [13:11]", 32'(cfgActive[13:11]), 32'd2);
    chk("R2 rr field [22:20]", 32'(cfgActive[22:20]), 32'd4);

    // R4: illegal width codes leave the setting
    setWidth(2'd2);
    chk("R4 width code 2 rejected", 32'(bus16), 32'd1);
    setWidth(2'd3);
    chk("R4 width code 3 rejected", 32'(bus16), 32'd1);
    setWidth(2'd0);
    chk("R4 width code 0 accepted", 32'(bus16), 32'd0);

    // R9: 8-bit mode masks the upper byte
    runReq(2'd3, 16'hA5C3, lowCnt, busyCnt, rdAt, fPad, fCle, fAle, fOe);
    chk("R9 padOut 8-bit", 32'(fPad), 32'h00C3);
    padIn = 16'hABCD;
    runReq(2'd2, 16'h0000, lowCnt, busyCnt, rdAt, fPad, fCle, fAle, fOe);
    chk("R9 rdData 8-bit", 32'(rdData), 32'h00CD);

    // R2 R5 R6 R7: vector table in 16-bit mode
    setWidth(2'd1);
    for (int v = 0; v < NVEC; v++) begin
      logic [3:0] rc, wc, eLow;
      logic [2:0] wp;
      logic [1:0] kd;
      logic [15:0] dv;
      logic [4:0] eBusy;
      {rc, wc, wp, kd, dv, eLow, eBusy} = VEC[v];
      setCfg(packCfg(rc, wc, 3'd1, wp, 3'd0, 3'd0, 3'd0));
      padIn = dv;
      runReq(kd, dv, lowCnt, busyCnt, rdAt, fPad, fCle, fAle, fOe);
      if (kd == 2'd2) begin
        chk($sformatf("R6 vec%0d reN low cycles", v), 32'(lowCnt), 32'(eLow));
        chk($sformatf("R6 vec%0d busy cycles", v), 32'(busyCnt), 32'(eBusy));
        chk($sformatf("R7 vec%0d rdValid index", v), 32'(rdAt), 32'd2);
        chk($sformatf("R7 vec%0d rdData", v), 32'(rdData), 32'(dv));
      end else begin
        chk($sformatf("R5 vec%0d weN low cycles", v), 32'(lowCnt), 32'(eLow));
        chk($sformatf("R5 vec%0d busy cycles", v), 32'(busyCnt), 32'(eBusy));
        chk($sformatf("R5 vec%0d padOut", v), 32'(fPad), 32'(dv));
        chk($sformatf("R8 vec%0d padOe/cle/ale", v), 32'({fOe, fCle, fAle}), 32'b100);
      end
    end

    // R8 R10: latch cycles and read hold after them
    setCfg(packCfg(4'd2, 4'd2, 3'd1, 3'd1, 3'd3, 3'd5, 3'd0));
    runReq(2'd0, 16'h1234, lowCnt, busyCnt, rdAt, fPad, fCle, fAle, fOe);
    chk("R8 cmd cle/ale/oe", 32'({fOe, fCle, fAle}), 32'b110);
    chk("R8 cmd low byte only", 32'(fPad), 32'h0034);
    countReadHold(holdCnt);
    chk("R10 hold after cmd", 32'(holdCnt), 32'd3);
    runReq(2'd1, 16'h5678, lowCnt, busyCnt, rdAt, fPad, fCle, fAle, fOe);
    chk("R8 addr cle/ale/oe", 32'({fOe, fCle, fAle}), 32'b101);
    chk("R8 addr low byte only", 32'(fPad), 32'h0078);
    countReadHold(holdCnt);
    chk("R10 hold after addr", 32'(holdCnt), 32'd5);

    // R11: device ready gating
    setCfg(packCfg(4'd2, 4'd2, 3'd1, 3'd1, 3'd0, 3'd0, 3'd4));
    devReady = 1'b0;
    reqKind = 2'd2; reqValid = 1'b1;
    step(); step(); step();
    chk("R11 read refused while busy", 32'(reqReady), 32'd0);
    chk("R11 no read strobe while busy", 32'(reN), 32'd1);
    devReady = 1'b1;
    #1;
    holdCnt = 0;
    while (!reqReady && holdCnt < 40) begin
      holdCnt++;
      step();
    end
    chk("R11 hold after ready rise", 32'(holdCnt), 32'd5);
    step();
    reqValid = 1'b0;
    chk("R11 read starts after hold", 32'(reN), 32'd0);
    repeat (4) step();

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule